// File: doc/BRIEF.md
# Paired-Page Translation Buffer

This block is a fully associative, software-managed address translation buffer. Each of its `ENTRIES` slots maps a naturally aligned pair of virtual pages (an even page and an odd page of the same size) under an 8-bit address-space identifier. The two pages of a pair have their own frame number, valid, dirty and cache attribute fields. One global flag per slot lets the slot match under any identifier. Five staging registers sit beside the array: a virtual-tag register (tag plus current identifier), two half-descriptor registers, a page-size mask register and a slot-index register. Software loads them through a simple register write port and reads them back on dedicated outputs.

Four one-cycle commands operate between the staging registers and the array. Probe searches for the current tag and identifier. Read copies a slot out into the staging registers. Write-indexed stores the staging registers into the slot named by the index register. Write-random stores them into the slot named by an externally supplied random value. A separate combinational port translates a virtual address with the current identifier. It returns the physical address, valid, dirty and cache attribute. It also reports either a miss or an access to an invalid half.

Top module: `pgpair_tlb`

## Requirements
- R1: After a synchronous active-low reset, every staging register reads zero, `cmd_done` is low, and every slot holds all-zero fields, so a read of any slot returns zero in all four entry registers.
- R2: Write-indexed (`cmd_op`=2) stores the staging registers into the slot given by the index register masked to `ENTRIES-1`. With 16 slots, index 0x13 writes slot 3.
- R3: Write-random (`cmd_op`=3) stores the staging registers into the slot given by `random_in`, independent of the index register.
- R4: The stored global flag is the AND of bit 0 of both half descriptors. A read returns that flag in bit 0 of both half-descriptor registers.
- R5: Read (`cmd_op`=1) rebuilds the tag register as tag bits 31:13, zeros in 12:8 and the identifier in 7:0. It rebuilds the mask register as the stored 8-bit mask at bits 20:13. It rebuilds each half register as frame in bits 25:6, cache attribute in 5:3, dirty in bit 2, valid in bit 1 and global in bit 0, with zeros above bit 25.
- R6: Probe (`cmd_op`=0) that finds a match writes the lowest matching slot number into the index register with bit 31 clear.
- R7: Probe without a match sets bit 31 of the index register and leaves its other bits unchanged.
- R8: A slot matches when its tag equals the presented tag outside the bits its mask ignores, and either its global flag is set or its identifier equals the current identifier.
- R9: Translate picks the odd half when virtual address bit 12+k is one, where k is the number of ones in the slot's mask, and the even half otherwise. The physical address is the frame shifted left by 12 with its low 12+k bits taken from the virtual address.
- R10: Mask bit i makes tag bit 13+i a don't-care in matching, so a set mask of k low ones widens each page to 4 KiB shifted left by k.
- R11: On every translate exactly one of `tr_miss`, `tr_valid` and `tr_invalid` is high. `tr_invalid` marks a tag match whose selected half has its valid bit clear. On a miss, the physical address, dirty and cache outputs are zero.
- R12: `cmd_done` pulses high for exactly the cycle after a cycle with `cmd_valid` high. A register write alone never raises it. A command's register update wins over a register write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Staging register write strobe |
| cfg_sel | input | 3 | Register select: 0 tag, 1 even half, 2 odd half, 3 mask, 4 index |
| cfg_wdata | input | 32 | Staging register write data |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 probe, 1 read, 2 write-indexed, 3 write-random |
| random_in | input | $clog2(ENTRIES) | Slot for write-random |
| tr_vaddr | input | 32 | Virtual address to translate |
| reg_entry_hi | output | 32 | Tag/identifier register |
| reg_entry_lo0 | output | 32 | Even-half descriptor register |
| reg_entry_lo1 | output | 32 | Odd-half descriptor register |
| reg_page_mask | output | 32 | Page-size mask register |
| reg_index | output | 32 | Slot index register, bit 31 probe miss |
| cmd_done | output | 1 | One-cycle completion pulse |
| tr_paddr | output | 32 | Translated physical address |
| tr_valid | output | 1 | Hit on a valid half |
| tr_dirty | output | 1 | Dirty bit of the selected half |
| tr_cattr | output | 3 | Cache attribute of the selected half |
| tr_miss | output | 1 | No slot matches |
| tr_invalid | output | 1 | Match on a half with valid clear |

## Verification
On every cycle the assertions check the completion pulse timing and that at most one slot is written per command. They check that the three translate outcomes are mutually exclusive and complete. After each probe, they check that the index register agrees with the search result, whether a hit slot number or the miss flag. Field packing on reads, mask-based page widening, odd/even selection, the global AND rule, lowest-slot priority and the index masking of write-indexed only show up in the bench's directed scenarios. Those scenarios compare whole register and address values against values worked out by hand.

// File: rtl/pgpair_tlb_pkg.sv
// Shared widths, command and register encodings, and entry layout for the
// paired-page translation buffer. Assumes 32-bit virtual and physical
// addresses and a 4 KiB minimum page.
package pgpair_tlb_pkg;

    localparam int REG_W      = 32;
    localparam int VA_W       = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int TAG_LSB    = 13;
    localparam int ASID_W     = 8;
    localparam int MASK_W     = 8;
    localparam int CACHE_W    = 3;
    localparam int PFN_LSB    = 6;
    localparam int PFN_W      = VA_W - PAGE_SHIFT;
    localparam int VPN2_W     = VA_W - TAG_LSB;
    localparam int SZ_W       = $clog2(MASK_W + 1);
    localparam int MISS_BIT   = 31;

    typedef enum logic [1:0] {
        OP_PROBE     = 2'd0,
        OP_READ      = 2'd1,
        OP_WRITE_IDX = 2'd2,
        OP_WRITE_RND = 2'd3
    } tlb_op_e;

    typedef enum logic [2:0] {
        SEL_HI    = 3'd0,
        SEL_LO0   = 3'd1,
        SEL_LO1   = 3'd2,
        SEL_MASK  = 3'd3,
        SEL_INDEX = 3'd4
    } tlb_reg_e;

    typedef struct packed {
        logic [PFN_W-1:0]   pfn;
        logic [CACHE_W-1:0] cattr;
        logic               dirty;
        logic               valid;
    } half_t;

    typedef struct packed {
        logic [VPN2_W-1:0] vpn2;
        logic [ASID_W-1:0] asid;
        logic [MASK_W-1:0] mask;
        logic              glob;
        half_t             even;
        half_t             odd;
    } entry_t;

    // Number of ones in a page mask, i.e. extra page-offset bits.
    function automatic logic [SZ_W-1:0] page_bits(input logic [MASK_W-1:0] m);
        logic [SZ_W-1:0] c;
        c = '0;
        for (int i = 0; i < MASK_W; i++) begin
            c = c + SZ_W'(m[i]);
        end
        return c;
    endfunction

    // Unpack one half descriptor register.
    function automatic half_t lo_to_half(input logic [REG_W-1:0] r);
        half_t h;
        h.pfn   = r[PFN_LSB +: PFN_W];
        h.cattr = r[3 +: CACHE_W];
        h.dirty = r[2];
        h.valid = r[1];
        return h;
    endfunction

    // Pack one half plus the global flag back into register layout.
    function automatic logic [REG_W-1:0] half_to_lo(input half_t h, input logic g);
        return REG_W'({h.pfn, h.cattr, h.dirty, h.valid, g});
    endfunction

endpackage

// File: rtl/pgpair_tlb_entry.sv
// One slot of the buffer: holds an entry and compares it against the probe
// tag and the translate address under the current identifier.
// Assumes the mask holds contiguous low ones; other patterns simply ignore
// the tag bits they mark.
module pgpair_tlb_entry
    import pgpair_tlb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  entry_t               wdata,
    input  logic [ASID_W-1:0]    cur_asid,
    input  logic [VPN2_W-1:0]    probe_vpn2,
    input  logic [VPN2_W-1:0]    xl_vpn2,
    output logic                 probe_match,
    output logic                 xl_match,
    output entry_t               ent
);

    entry_t            store_q;
    logic [VPN2_W-1:0] keep;
    logic              id_ok;

    // Slot storage: cleared on reset, replaced whole on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= '0;
        end else if (we) begin
            store_q <= wdata;
        end
    end

    // Match logic: masked tag compare plus identifier or global.
    always_comb begin
        keep        = ~VPN2_W'(store_q.mask);
        id_ok       = store_q.glob | (store_q.asid == cur_asid);
        probe_match = id_ok & (((store_q.vpn2 ^ probe_vpn2) & keep) == '0);
        xl_match    = id_ok & (((store_q.vpn2 ^ xl_vpn2) & keep) == '0);
    end

    assign ent = store_q;

endmodule

// File: rtl/pgpair_tlb_first.sv
// Priority encoder: reports whether any request is set and the lowest set
// position. Assumes N is at least 2.
module pgpair_tlb_first #(
    parameter int N = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);

    // Scan from the top down so the lowest set request wins.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IW'(i);
            end
        end
        any = |req;
    end

endmodule

// File: rtl/pgpair_tlb_xlate.sv
// Translate datapath: given the matching entry, selects the even or odd
// half from the address bit above the page offset and forms the physical
// address. Assumes physical and virtual addresses share one width.
module pgpair_tlb_xlate
    import pgpair_tlb_pkg::*;
(
    input  entry_t             ent,
    input  logic               hit,
    input  logic [VA_W-1:0]    vaddr,
    output logic [VA_W-1:0]    paddr,
    output logic               valid,
    output logic               dirty,
    output logic [CACHE_W-1:0] cattr,
    output logic               miss,
    output logic               invalid
);

    int unsigned     shamt;
    logic [VA_W-1:0] above;
    logic [VA_W-1:0] omask;
    half_t           half;

    // Half selection and address composition.
    always_comb begin
        shamt   = PAGE_SHIFT + 32'(page_bits(ent.mask));
        above   = vaddr >> shamt;
        omask   = ~({VA_W{1'b1}} << shamt);
        half    = above[0] ? ent.odd : ent.even;
        miss    = ~hit;
        valid   = hit & half.valid;
        invalid = hit & ~half.valid;
        dirty   = hit & half.dirty;
        cattr   = hit ? half.cattr : '0;
        paddr   = hit ? (({half.pfn, {PAGE_SHIFT{1'b0}}} & ~omask) | (vaddr & omask))
                      : '0;
    end

endmodule

// File: rtl/pgpair_tlb.sv
// Top of the paired-page translation buffer: staging registers, command
// execution (probe, read, write-indexed, write-random) and the slot array
// with its translate port. Assumes ENTRIES is a power of two; commands
// complete in one cycle and the random slot is supplied from outside.
module pgpair_tlb
    import pgpair_tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_sel,
    input  logic [REG_W-1:0]   cfg_wdata,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic [IDX_W-1:0]   random_in,
    input  logic [VA_W-1:0]    tr_vaddr,
    output logic [REG_W-1:0]   reg_entry_hi,
    output logic [REG_W-1:0]   reg_entry_lo0,
    output logic [REG_W-1:0]   reg_entry_lo1,
    output logic [REG_W-1:0]   reg_page_mask,
    output logic [REG_W-1:0]   reg_index,
    output logic               cmd_done,
    output logic [VA_W-1:0]    tr_paddr,
    output logic               tr_valid,
    output logic               tr_dirty,
    output logic [CACHE_W-1:0] tr_cattr,
    output logic               tr_miss,
    output logic               tr_invalid
);

    logic [REG_W-1:0] hi_q, lo0_q, lo1_q, mask_q, index_q;
    logic             done_q;

    tlb_op_e          op;
    tlb_reg_e         sel;
    entry_t           wr_ent;
    logic [IDX_W-1:0] wr_slot;
    logic             wr_cmd;
    logic [ENTRIES-1:0] entry_we;
    logic [ENTRIES-1:0] probe_hits;
    logic [ENTRIES-1:0] xl_hits;
    entry_t           ent_q [ENTRIES];
    logic             probe_hit;
    logic [IDX_W-1:0] probe_idx;
    logic             xl_hit;
    logic [IDX_W-1:0] xl_idx;
    entry_t           rd_ent;

    assign op  = tlb_op_e'(cmd_op);
    assign sel = tlb_reg_e'(cfg_sel);

    // Build the entry image that a write command stores.
    always_comb begin
        wr_ent.vpn2 = hi_q[TAG_LSB +: VPN2_W];
        wr_ent.asid = hi_q[ASID_W-1:0];
        wr_ent.mask = mask_q[TAG_LSB +: MASK_W];
        wr_ent.glob = lo0_q[0] & lo1_q[0];
        wr_ent.even = lo_to_half(lo0_q);
        wr_ent.odd  = lo_to_half(lo1_q);
    end

    // Choose the target slot and whether this cycle writes the array.
    always_comb begin
        wr_cmd  = cmd_valid & ((op == OP_WRITE_IDX) | (op == OP_WRITE_RND));
        wr_slot = (op == OP_WRITE_RND) ? random_in : index_q[IDX_W-1:0];
    end

    // Slot array, one instance per entry.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        assign entry_we[i] = wr_cmd & (wr_slot == IDX_W'(i));
        pgpair_tlb_entry u_ent (
            .clk         (clk),
            .rst_n       (rst_n),
            .we          (entry_we[i]),
            .wdata       (wr_ent),
            .cur_asid    (hi_q[ASID_W-1:0]),
            .probe_vpn2  (hi_q[TAG_LSB +: VPN2_W]),
            .xl_vpn2     (tr_vaddr[TAG_LSB +: VPN2_W]),
            .probe_match (probe_hits[i]),
            .xl_match    (xl_hits[i]),
            .ent         (ent_q[i])
        );
    end

    pgpair_tlb_first #(.N(ENTRIES)) u_probe_pe (
        .req (probe_hits),
        .any (probe_hit),
        .idx (probe_idx)
    );

    pgpair_tlb_first #(.N(ENTRIES)) u_xl_pe (
        .req (xl_hits),
        .any (xl_hit),
        .idx (xl_idx)
    );

    pgpair_tlb_xlate u_xlate (
        .ent     (ent_q[xl_idx]),
        .hit     (xl_hit),
        .vaddr   (tr_vaddr),
        .paddr   (tr_paddr),
        .valid   (tr_valid),
        .dirty   (tr_dirty),
        .cattr   (tr_cattr),
        .miss    (tr_miss),
        .invalid (tr_invalid)
    );

    assign rd_ent = ent_q[index_q[IDX_W-1:0]];

    // Staging registers: software writes first, command results override.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q    <= '0;
            lo0_q   <= '0;
            lo1_q   <= '0;
            mask_q  <= '0;
            index_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= cmd_valid;
            if (cfg_we) begin
                case (sel)
                    SEL_HI:    hi_q    <= cfg_wdata;
                    SEL_LO0:   lo0_q   <= cfg_wdata;
                    SEL_LO1:   lo1_q   <= cfg_wdata;
                    SEL_MASK:  mask_q  <= cfg_wdata;
                    SEL_INDEX: index_q <= cfg_wdata;
                    default:   ;
                endcase
            end
            if (cmd_valid && op == OP_PROBE) begin
                if (probe_hit) begin
                    index_q <= REG_W'(probe_idx);
                end else begin
                    index_q <= index_q | (REG_W'(1) << MISS_BIT);
                end
            end
            if (cmd_valid && op == OP_READ) begin
                hi_q   <= {rd_ent.vpn2, {(TAG_LSB - ASID_W){1'b0}}, rd_ent.asid};
                mask_q <= REG_W'(rd_ent.mask) << TAG_LSB;
                lo0_q  <= half_to_lo(rd_ent.even, rd_ent.glob);
                lo1_q  <= half_to_lo(rd_ent.odd, rd_ent.glob);
            end
        end
    end

    assign reg_entry_hi  = hi_q;
    assign reg_entry_lo0 = lo0_q;
    assign reg_entry_lo1 = lo1_q;
    assign reg_page_mask = mask_q;
    assign reg_index     = index_q;
    assign cmd_done      = done_q;

endmodule

// File: rtl/pgpair_tlb_chk.sv
// Property checker for the paired-page translation buffer, attached to the
// top by bind. Observes ports plus the probe result and write strobes.
module pgpair_tlb_chk
    import pgpair_tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_valid,
    input logic [1:0]         cmd_op,
    input logic               cmd_done,
    input logic [REG_W-1:0]   reg_index,
    input logic               tr_miss,
    input logic               tr_valid,
    input logic               tr_invalid,
    input logic               probe_hit,
    input logic [IDX_W-1:0]   probe_idx,
    input logic [ENTRIES-1:0] entry_we
);

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (reg_index == '0 && !cmd_done));

    assert_one_slot_written_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(entry_we));

    assert_probe_hit_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_PROBE && probe_hit)
        |=> (reg_index == REG_W'($past(probe_idx))));

    assert_probe_miss_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_PROBE && !probe_hit)
        |=> (reg_index[MISS_BIT] && reg_index[MISS_BIT-1:0] == $past(reg_index[MISS_BIT-1:0])));

    assert_outcome_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({tr_miss, tr_valid, tr_invalid}) == 1);

    assert_done_after_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> cmd_done);

    assert_no_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !cmd_done);

endmodule

bind pgpair_tlb pgpair_tlb_chk #(.ENTRIES(ENTRIES)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_done   (cmd_done),
    .reg_index  (reg_index),
    .tr_miss    (tr_miss),
    .tr_valid   (tr_valid),
    .tr_invalid (tr_invalid),
    .probe_hit  (probe_hit),
    .probe_idx  (probe_idx),
    .entry_we   (entry_we)
);

// File: tb/pgpair_tlb_tb_top.sv
// Directed bench for the paired-page translation buffer: one task per
// scenario, each comparing outputs against hand-derived values.
module pgpair_tlb_tb_top;
    import pgpair_tlb_pkg::*;

    localparam int ENTRIES = 16;
    localparam int IDX_W   = $clog2(ENTRIES);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cfg_we = 1'b0;
    logic [2:0]         cfg_sel = '0;
    logic [31:0]        cfg_wdata = '0;
    logic               cmd_valid = 1'b0;
    logic [1:0]         cmd_op = '0;
    logic [IDX_W-1:0]   random_in = '0;
    logic [31:0]        tr_vaddr = '0;
    logic [31:0]        reg_entry_hi, reg_entry_lo0, reg_entry_lo1, reg_page_mask, reg_index;
    logic               cmd_done;
    logic [31:0]        tr_paddr;
    logic               tr_valid, tr_dirty, tr_miss, tr_invalid;
    logic [2:0]         tr_cattr;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pgpair_tlb #(.ENTRIES(ENTRIES)) dut_i (
        .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata, .cmd_valid, .cmd_op,
        .random_in, .tr_vaddr, .reg_entry_hi, .reg_entry_lo0, .reg_entry_lo1,
        .reg_page_mask, .reg_index, .cmd_done, .tr_paddr, .tr_valid,
        .tr_dirty, .tr_cattr, .tr_miss, .tr_invalid
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R12 no done on register write", 32'(cmd_done), 32'd0);
    endtask

    task automatic run_cmd(input logic [1:0] op);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R12 done pulse", 32'(cmd_done), 32'd1);
        @(negedge clk);
        chk("R12 done falls", 32'(cmd_done), 32'd0);
    endtask

    task automatic load(input logic [31:0] hi, input logic [31:0] l0,
                        input logic [31:0] l1, input logic [31:0] pm);
        wr_reg(SEL_HI, hi); wr_reg(SEL_LO0, l0); wr_reg(SEL_LO1, l1); wr_reg(SEL_MASK, pm);
    endtask

    task automatic read_slot(input logic [31:0] idx);
        wr_reg(SEL_INDEX, idx);
        run_cmd(OP_READ);
    endtask

    task automatic xl(input string req, input logic [31:0] va, input logic [31:0] pa,
                      input logic v, input logic d, input logic [2:0] c,
                      input logic m, input logic inv);
        @(negedge clk);
        tr_vaddr = va;
        #1;
        chk({req, " paddr"}, tr_paddr, pa);
        chk({req, " flags"}, {27'd0, v, d, m, inv, 1'b0}, {27'd0, tr_valid, tr_dirty, tr_miss, tr_invalid, 1'b0});
        chk({req, " cattr"}, 32'(tr_cattr), 32'(c));
    endtask

    task automatic t_reset;
        chk("R1 hi", reg_entry_hi, 0);
        chk("R1 index", reg_index, 0);
        chk("R1 done", 32'(cmd_done), 0);
        read_slot(32'd7);
        chk("R1 slot hi", reg_entry_hi, 0);
        chk("R1 slot lo0", reg_entry_lo0, 0);
        chk("R1 slot lo1", reg_entry_lo1, 0);
        chk("R1 slot mask", reg_page_mask, 0);
    endtask

    task automatic t_write_read;
        load(32'hABCD_FF5A, 32'h8048_D15F, 32'h002A_F353, 32'h0);
        wr_reg(SEL_INDEX, 32'h13);
        run_cmd(OP_WRITE_IDX);
        load(0, 0, 0, 0);
        read_slot(32'd3);
        chk("R2 R5 hi rebuilt slot 3", reg_entry_hi, 32'hABCD_E05A);
        chk("R4 R5 lo0", reg_entry_lo0, 32'h0048_D15F);
        chk("R4 R5 lo1", reg_entry_lo1, 32'h002A_F353);
        chk("R5 mask", reg_page_mask, 32'h0);
    endtask

    task automatic t_global_and;
        load(32'h0001_0077, 32'h0000_0003, 32'h0000_0000, 32'h0);
        wr_reg(SEL_INDEX, 32'd5);
        run_cmd(OP_WRITE_IDX);
        read_slot(32'd5);
        chk("R4 lo0 g cleared", reg_entry_lo0, 32'h2);
        chk("R4 lo1 g cleared", reg_entry_lo1, 32'h0);
    endtask

    task automatic t_random;
        load(32'h0040_0011, 32'h0000_0043, 32'h0000_0003, 32'h0);
        wr_reg(SEL_INDEX, 32'd2);
        random_in = 4'd9;
        run_cmd(OP_WRITE_RND);
        read_slot(32'd9);
        chk("R3 random slot hi", reg_entry_hi, 32'h0040_0011);
        chk("R3 random slot lo0", reg_entry_lo0, 32'h0000_0043);
        read_slot(32'd2);
        chk("R3 index slot untouched", reg_entry_hi, 32'h0);
    endtask

    task automatic t_probe;
        load(32'h0001_0077, 32'h3, 32'h3, 32'h0);
        wr_reg(SEL_INDEX, 32'd7);
        run_cmd(OP_WRITE_IDX);
        wr_reg(SEL_HI, 32'h0001_0077);
        run_cmd(OP_PROBE);
        chk("R6 lowest match", reg_index, 32'd5);
        wr_reg(SEL_HI, 32'h0001_0078);
        wr_reg(SEL_INDEX, 32'd5);
        run_cmd(OP_PROBE);
        chk("R8 R6 global slot 7 matches other id", reg_index, 32'd7);
        wr_reg(SEL_HI, 32'h0002_0078);
        run_cmd(OP_PROBE);
        chk("R7 miss flag keeps bits", reg_index, 32'h8000_0007);
        wr_reg(SEL_HI, 32'hABCD_E033);
        run_cmd(OP_PROBE);
        chk("R8 global ignores id", reg_index, 32'd3);
    endtask

    task automatic t_translate;
        wr_reg(SEL_HI, 32'h0000_0011);
        xl("R9 even", 32'hABCD_E123, 32'h1234_5123, 1, 1, 3'd3, 0, 0);
        xl("R9 odd", 32'hABCD_F456, 32'h0ABC_D456, 1, 0, 3'd2, 0, 0);
        xl("R9 next pair misses", 32'hABCE_0000, 32'h0, 0, 0, 3'd0, 1, 0);
        wr_reg(SEL_HI, 32'h0000_0077);
        // slot 5 (id 0x77, not global) precedes slot 7: odd half of slot 5 invalid
        xl("R11 invalid half", 32'h0001_1000, 32'h0, 0, 0, 3'd0, 0, 1);
        xl("R11 valid even", 32'h0001_0ABC, 32'h0000_0ABC, 1, 0, 3'd0, 0, 0);
        xl("R11 miss", 32'h7000_0000, 32'h0, 0, 0, 3'd0, 1, 0);
    endtask

    task automatic t_big_page;
        load(32'h4000_0077, 32'h0140_0003, 32'h0180_0007, 32'h0000_6000);
        wr_reg(SEL_INDEX, 32'd10);
        run_cmd(OP_WRITE_IDX);
        xl("R10 odd 16K", 32'h4000_6ABC, 32'h6000_2ABC, 1, 1, 3'd0, 0, 0);
        xl("R10 even 16K", 32'h4000_1234, 32'h5000_1234, 1, 0, 3'd0, 0, 0);
        wr_reg(SEL_MASK, 32'h0);
        read_slot(32'd10);
        chk("R5 mask rebuilt", reg_page_mask, 32'h0000_6000);
    endtask

    task automatic t_override;
        wr_reg(SEL_INDEX, 32'd3);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = OP_READ;
        cfg_we = 1'b1; cfg_sel = SEL_HI; cfg_wdata = 32'h1111_1111;
        @(negedge clk);
        cmd_valid = 1'b0; cfg_we = 1'b0;
        chk("R12 command wins over write", reg_entry_hi, 32'hABCD_E05A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_read();
        t_global_and();
        t_random();
        t_probe();
        t_translate();
        t_big_page();
        t_override();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule